// File: doc/BRIEF.md
# Disk Attachment Interrupt Status Collector

This block is the host-side service engine for interrupts raised by a disk controller attachment. It waits for the interrupt flag of the attachment's basic status register. It then reads the interrupt status register once, which clears the interrupt condition, and keeps the device number and the interrupt identifier from that byte. If the status interface register reports a word ready, the block drains a status block of variable length, one 16-bit word at a time. Each word is taken only while the full flag is set. The words go into a local buffer of `WORDS` entries.

Once the block is drained, a single dispatch cycle classifies the interrupt as ignore, done, error or fatal. In the same cycle the block raises the follow-up strobes: a DMA-enable control write request, or an end-of-interrupt attention request tagged with the device number. It also latches the residual block count when a read or write command has finished. The register file, the DMA engine and the attention sequencer sit outside the block and see only these strobes.

The controller is a five-state machine:
- IDLE goes to RD_ISR when the interrupt flag is seen.
- RD_ISR strobes the status byte read. It goes to DISPATCH for a reserved identifier and to CHK_SIF otherwise.
- CHK_SIF takes the first word if one is ready. It goes to FETCH when more words are announced and to DISPATCH otherwise.
- FETCH takes one word each time the full flag is set. It goes to DISPATCH after the last announced word.
- DISPATCH lasts one cycle and returns to IDLE.

Top module: `isr_collector`

## Requirements
- R1: No status byte read (`isr_rd`) and no status word read (`sif_rd`) happens unless the interrupt flag `stat_irq` has been seen. Each service issues exactly one `isr_rd` strobe.
- R2: In the status byte, bits 7:5 are the device number and bits 3:0 are the interrupt identifier. Identifiers 0, 2 and 4 are spurious. For a spurious identifier the block reads no status word, requests no end of interrupt, and reports outcome ignore.
- R3: If `stat_sif_full` is set in CHK_SIF, the first word is taken. Its bits 15:8 give the block length and its bits 4:0 give the command code. Each later word is read only in a cycle where `stat_sif_full` is set. Exactly max(length,1) words are read.
- R4: The buffer is cleared at the start of every service. Entries at or beyond the received length read as zero, and all entries are zero when no status block was offered.
- R5: A length above `WORDS` sets `overflow` for that service. Only the first `WORDS` words are stored, and the remaining words are still drained.
- R6: `result` is encoded as 0 ignore, 1 done, 2 error, 3 fatal. Identifiers 1, 3, 5 and 8 give done. Identifiers 9 (aborted), 10 (reset completed) and 11 (transfer ready) give ignore. Identifier 15 gives fatal. Identifiers 6, 7, 12, 13 and 14 give error.
- R7: Identifier 11 raises `dma_en_req` for one cycle and no end-of-interrupt request.
- R8: All identifiers except the spurious ones, 11 and 15 raise `eoi_req` in the dispatch cycle, with `eoi_dev` equal to the device number from the status byte.
- R9: When a status block was taken, its command code is 1 (read) or 2 (write), and the identifier is not 11, the block pulses `resid_upd` and loads `resid_cnt` from buffer word `RESID_IDX` (default 2). In all other cases `resid_cnt` keeps its value.
- R10: Identifier 15 sets `fatal`, which stays set until reset.
- R11: `result_valid` rises for one cycle. This happens in the cycle after the last status word is read, or 2 cycles after the interrupt flag is sampled for a spurious identifier, or 3 cycles after it when no more than one word is taken.
- R12: After reset all strobes, `overflow`, `fatal`, `resid_cnt` and the buffer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_irq | input | 1 | Interrupt flag of the basic status register |
| stat_sif_full | input | 1 | Status interface register holds a word |
| isr_rd | output | 1 | Read strobe for the interrupt status byte |
| isr_data | input | 8 | Interrupt status byte, valid during `isr_rd` |
| sif_rd | output | 1 | Read strobe for one status word |
| sif_data | input | DW | Status word, valid during `sif_rd` |
| dma_en_req | output | 1 | Request a control write enabling interrupts and DMA |
| eoi_req | output | 1 | Request an end-of-interrupt attention |
| eoi_dev | output | 3 | Device number for the end-of-interrupt attention |
| result_valid | output | 1 | Dispatch cycle marker |
| result | output | 2 | Outcome: 0 ignore, 1 done, 2 error, 3 fatal |
| overflow | output | 1 | Last status block was longer than the buffer |
| resid_upd | output | 1 | Residual count loaded this cycle |
| resid_cnt | output | DW | Latched residual block count |
| fatal | output | 1 | Sticky attention-error flag |
| sblk | output | WORDS*DW | Status block buffer, word 0 in the low bits |

## Verification
The bench builds the block with its defaults: an 8-word buffer of 16-bit words, the residual count at word index 2, and read and write command codes 1 and 2. With only eight entries, a ten-word status block exercises the truncation and drain-through path. Three-word blocks place the residual word just inside the received length. The register stub can hold the full flag low for a few cycles between words, which shows that reads are gated on the flag and that the latency stretches by exactly the inserted gap.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISR,
        S_CHK_SIF,
        S_FETCH,
        S_DISPATCH
    } isc_state_e;

    typedef enum logic [1:0] {
        OUT_IGNORE = 2'd0,
        OUT_DONE   = 2'd1,
        OUT_ERROR  = 2'd2,
        OUT_FATAL  = 2'd3
    } isc_outcome_e;

    localparam logic [3:0] ID_XFER_READY = 4'hB;
    localparam logic [3:0] ID_ATTN_ERROR = 4'hF;

    function automatic logic id_reserved(input logic [3:0] id);
        return (id == 4'd0) || (id == 4'd2) || (id == 4'd4);
    endfunction

endpackage

// File: rtl/isc_classify.sv
module isc_classify
    import isc_pkg::*;
(
    input  logic [3:0]   id,
    output isc_outcome_e outcome,
    output logic         want_eoi,
    output logic         want_dma
);
    always_comb begin
        outcome  = OUT_ERROR;
        want_eoi = 1'b1;
        want_dma = 1'b0;
        case (id)
            4'd1, 4'd3, 4'd5, 4'd8: outcome = OUT_DONE;
            4'd9, 4'hA:             outcome = OUT_IGNORE;
            ID_XFER_READY: begin
                outcome  = OUT_IGNORE;
                want_eoi = 1'b0;
                want_dma = 1'b1;
            end
            ID_ATTN_ERROR: begin
                outcome  = OUT_FATAL;
                want_eoi = 1'b0;
            end
            4'd0, 4'd2, 4'd4: begin
                outcome  = OUT_IGNORE;
                want_eoi = 1'b0;
            end
            default:                outcome = OUT_ERROR;
        endcase
    end
endmodule

// File: rtl/isc_sblk_buf.sv
module isc_sblk_buf #(
    parameter int WORDS = 8,
    parameter int DW    = 16,
    localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [WORDS*DW-1:0] flat
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                word_q <= '0;
            else if (wr && (wr_idx == IW'(g)))
                word_q <= wr_data;
        end
        assign flat[g*DW +: DW] = word_q;
    end
endmodule

// File: rtl/isr_collector.sv
module isr_collector
    import isc_pkg::*;
#(
    parameter int WORDS     = 8,
    parameter int DW        = 16,
    parameter int RESID_IDX = 2,
    parameter int CMD_READ  = 1,
    parameter int CMD_WRITE = 2,
    localparam int IW       = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LEN_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stat_irq,
    input  logic                stat_sif_full,
    output logic                isr_rd,
    input  logic [7:0]          isr_data,
    output logic                sif_rd,
    input  logic [DW-1:0]       sif_data,
    output logic                dma_en_req,
    output logic                eoi_req,
    output logic [2:0]          eoi_dev,
    output logic                result_valid,
    output logic [1:0]          result,
    output logic                overflow,
    output logic                resid_upd,
    output logic [DW-1:0]       resid_cnt,
    output logic                fatal,
    output logic [WORDS*DW-1:0] sblk
);
    isc_state_e         state_q, state_d;
    logic [2:0]         dev_q;
    logic [3:0]         id_q;
    logic               blk_q;
    logic [4:0]         cmd_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   cnt_q;
    logic               ovf_q;
    logic [DW-1:0]      resid_q;
    logic               fatal_q;

    isc_outcome_e       cls_outcome;
    logic               cls_eoi, cls_dma;
    logic               buf_clr, buf_wr;
    logic [IW-1:0]      buf_idx;
    logic               is_rw;

    isc_classify u_classify (
        .id       (id_q),
        .outcome  (cls_outcome),
        .want_eoi (cls_eoi),
        .want_dma (cls_dma)
    );

    isc_sblk_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (buf_wr),
        .wr_idx  (buf_idx),
        .wr_data (sif_data),
        .flat    (sblk)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (stat_irq) state_d = S_RD_ISR;
            S_RD_ISR:   state_d = id_reserved(isr_data[3:0]) ? S_DISPATCH : S_CHK_SIF;
            S_CHK_SIF:  state_d = (stat_sif_full && (sif_data[15:8] > 8'd1)) ? S_FETCH : S_DISPATCH;
            S_FETCH:    if (stat_sif_full && ((cnt_q + 8'd1) == len_q)) state_d = S_DISPATCH;
            S_DISPATCH: state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    assign is_rw = (cmd_q == 5'(CMD_READ)) || (cmd_q == 5'(CMD_WRITE));

    // outputs
    always_comb begin
        isr_rd       = (state_q == S_RD_ISR);
        sif_rd       = ((state_q == S_CHK_SIF) || (state_q == S_FETCH)) && stat_sif_full;
        result_valid = (state_q == S_DISPATCH);
        result       = result_valid ? cls_outcome : OUT_IGNORE;
        dma_en_req   = result_valid && cls_dma;
        eoi_req      = result_valid && cls_eoi;
        eoi_dev      = dev_q;
        resid_upd    = result_valid && blk_q && is_rw && (id_q != ID_XFER_READY);
        overflow     = ovf_q;
        resid_cnt    = resid_q;
        fatal        = fatal_q;
        buf_clr      = (state_q == S_RD_ISR);
        buf_wr       = sif_rd && (cnt_q < LEN_W'(WORDS) || state_q == S_CHK_SIF);
        buf_idx      = (state_q == S_CHK_SIF) ? '0 : cnt_q[IW-1:0];
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q   <= '0;
            id_q    <= '0;
            blk_q   <= 1'b0;
            cmd_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
            resid_q <= '0;
            fatal_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_RD_ISR: begin
                    dev_q <= isr_data[7:5];
                    id_q  <= isr_data[3:0];
                    blk_q <= 1'b0;
                    ovf_q <= 1'b0;
                end
                S_CHK_SIF: begin
                    blk_q <= stat_sif_full;
                    if (stat_sif_full) begin
                        len_q <= sif_data[15:8];
                        cmd_q <= sif_data[4:0];
                        cnt_q <= 8'd1;
                        ovf_q <= sif_data[15:8] > LEN_W'(WORDS);
                    end
                end
                S_FETCH:
                    if (stat_sif_full) cnt_q <= cnt_q + 8'd1;
                S_DISPATCH: begin
                    if (resid_upd) resid_q <= sblk[RESID_IDX*DW +: DW];
                    if (cls_outcome == OUT_FATAL) fatal_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stat_irq,
    input logic          stat_sif_full,
    input logic          isr_rd,
    input logic          sif_rd,
    input logic          dma_en_req,
    input logic          eoi_req,
    input logic          result_valid,
    input logic [1:0]    result,
    input logic          resid_upd,
    input logic [DW-1:0] resid_cnt,
    input logic          fatal
);
    a_r1_read_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rd |-> $past(stat_irq));

    a_r3_word_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        sif_rd |-> stat_sif_full);

    a_r7_dma_without_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_req |-> (!eoi_req && result_valid && result == 2'd0));

    a_r8_eoi_not_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_req |-> (result_valid && result != 2'd3));

    a_r6_done_acknowledged: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && result == 2'd1) |-> eoi_req);

    a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);

    a_r11_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r9_resid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !resid_upd |=> $stable(resid_cnt));
endmodule

bind isr_collector isc_checker #(.DW(DW)) i_isc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .stat_irq      (stat_irq),
    .stat_sif_full (stat_sif_full),
    .isr_rd        (isr_rd),
    .sif_rd        (sif_rd),
    .dma_en_req    (dma_en_req),
    .eoi_req       (eoi_req),
    .result_valid  (result_valid),
    .result        (result),
    .resid_upd     (resid_upd),
    .resid_cnt     (resid_cnt),
    .fatal         (fatal)
);

// File: tb/test_isr_collector.sv
module test_isr_collector;
    localparam int WORDS = 8;
    localparam int DW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // register stub
    logic          irq_q = 1'b0;
    logic [7:0]    isr_q = '0;
    logic [DW-1:0] wq[$];
    int            gap = 0;
    int            hold = 0;
    logic          sif_full;
    logic [DW-1:0] sif_word;

    logic                isr_rd, sif_rd, dma_en_req, eoi_req, result_valid;
    logic                overflow, resid_upd, fatal;
    logic [2:0]          eoi_dev;
    logic [1:0]          result;
    logic [DW-1:0]       resid_cnt;
    logic [WORDS*DW-1:0] sblk;

    isr_collector i_isr_collector (
        .clk(clk), .rst_n(rst_n), .stat_irq(irq_q), .stat_sif_full(sif_full),
        .isr_rd(isr_rd), .isr_data(isr_q), .sif_rd(sif_rd), .sif_data(sif_word),
        .dma_en_req(dma_en_req), .eoi_req(eoi_req), .eoi_dev(eoi_dev),
        .result_valid(result_valid), .result(result), .overflow(overflow),
        .resid_upd(resid_upd), .resid_cnt(resid_cnt), .fatal(fatal), .sblk(sblk)
    );

    always_comb begin
        sif_full = (wq.size() > 0) && (hold == 0);
        sif_word = (wq.size() > 0) ? wq[0] : '0;
    end

    always @(posedge clk) begin
        if (isr_rd) irq_q <= 1'b0;
        if (sif_rd) begin
            void'(wq.pop_front());
            hold <= gap;
        end else if (hold > 0) begin
            hold <= hold - 1;
        end
    end

    int checks = 0;
    int fails  = 0;
    int isr_seen = 0;
    int sif_seen = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // every-clock reference: strobes only in the dispatch cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (isr_rd) isr_seen++;
            if (sif_rd) sif_seen++;
            if (!result_valid)
                chk(!(eoi_req || dma_en_req || resid_upd), "R11", "strobe outside dispatch",
                    {eoi_req, dma_en_req, resid_upd}, 0);
        end
    end

    logic [DW-1:0] stim[$];
    logic [DW-1:0] exp_resid = '0;
    bit            exp_fatal = 1'b0;

    task automatic service(input logic [3:0] id, input logic [2:0] dev, input int g);
        int lat = 0;
        int len, nw, exp_lat, isr0, sif0;
        bit blk, rsv, is_done, is_ign, rw;
        int exp_res;
        logic [DW-1:0] w;
        blk = stim.size() > 0;
        rsv = (id == 0) || (id == 2) || (id == 4);
        len = blk ? int'(stim[0][15:8]) : 0;
        nw  = blk ? ((len > 1) ? len : 1) : 0;
        rw  = blk && (stim[0][4:0] == 5'd1 || stim[0][4:0] == 5'd2);
        is_done = (id == 1) || (id == 3) || (id == 5) || (id == 8);
        is_ign  = rsv || (id == 9) || (id == 10) || (id == 11);
        exp_res = is_done ? 1 : (is_ign ? 0 : ((id == 15) ? 3 : 2));
        exp_lat = rsv ? 2 : ((nw <= 1) ? 3 : 3 + (nw - 1) * (g + 1));
        isr0 = isr_seen;
        sif0 = sif_seen;
        @(negedge clk);
        gap = g;
        foreach (stim[i]) wq.push_back(stim[i]);
        isr_q = {dev, 1'b0, id};
        irq_q = 1'b1;
        while (1) begin
            @(negedge clk);
            lat++;
            if (result_valid || lat > 400) break;
        end
        chk(lat == exp_lat, "R11", "dispatch latency", lat, exp_lat);
        chk(result == 2'(exp_res), "R6", "outcome", result, exp_res);
        chk(dma_en_req == (id == 11), "R7", "dma request", dma_en_req, id == 11);
        chk(eoi_req == (!rsv && id != 11 && id != 15), "R8", "eoi request",
            eoi_req, !rsv && id != 11 && id != 15);
        if (eoi_req) chk(eoi_dev == dev, "R8", "eoi device", eoi_dev, dev);
        chk(overflow == (len > WORDS), "R5", "overflow", overflow, len > WORDS);
        chk((isr_seen - isr0) == 1, "R1", "status byte reads", isr_seen - isr0, 1);
        chk((sif_seen - sif0) == nw, rsv ? "R2" : "R3", "status words read", sif_seen - sif0, nw);
        for (int i = 0; i < WORDS; i++) begin
            w = (blk && i < nw) ? stim[i] : '0;
            chk(sblk[i*DW +: DW] == w, (len > WORDS) ? "R5" : "R4", "buffer word",
                sblk[i*DW +: DW], w);
        end
        chk(resid_upd == (rw && id != 11), "R9", "residual update", resid_upd, rw && id != 11);
        if (rw && id != 11) exp_resid = sblk[2*DW +: DW];
        if (id == 15) exp_fatal = 1'b1;
        @(negedge clk);
        chk(resid_cnt == exp_resid, "R9", "residual count", resid_cnt, exp_resid);
        chk(fatal == exp_fatal, "R10", "fatal flag", fatal, exp_fatal);
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!(isr_rd || sif_rd || eoi_req || dma_en_req || result_valid || resid_upd),
            "R12", "strobes in reset", 1, 0);
        chk(sblk == '0 && resid_cnt == '0 && !fatal && !overflow, "R12", "state in reset",
            resid_cnt, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: a ready status word without the interrupt flag is left alone
        wq.push_back(16'h0101);
        repeat (20) @(negedge clk);
        chk(isr_seen == 0 && sif_seen == 0, "R1", "reads without flag", isr_seen + sif_seen, 0);
        chk(wq.size() == 1, "R1", "stub queue untouched", wq.size(), 1);
        wq.delete();
        repeat (2) @(negedge clk);

        // completed read, four words
        stim = '{16'h0401, 16'h1111, 16'h0007, 16'h3333};
        service(4'd1, 3'd3, 0);
        // completed with ECC, write, gaps between words (R3)
        stim = '{16'h0302, 16'hA0A0, 16'h0042};
        service(4'd3, 3'd1, 2);
        // transfer ready: DMA, no EOI, residual held (R7, R9)
        stim = '{16'h0301, 16'h5555, 16'h0099};
        service(4'hB, 3'd2, 0);
        // failed, non-transfer command
        stim = '{16'h0609, 16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0005};
        service(4'hC, 3'd5, 1);
        // overflow: ten words announced (R5)
        stim = '{16'h0A01, 16'h0101, 16'h0202, 16'h0303, 16'h0404, 16'h0505,
                 16'h0606, 16'h0707, 16'h0808, 16'h0909};
        service(4'd5, 3'd0, 0);
        // warning without status block (R4)
        stim = {};
        service(4'd8, 3'd6, 0);
        // one-word block, read command, residual index beyond length (R4, R9)
        stim = '{16'h0101};
        service(4'd1, 3'd1, 0);
        // spurious identifiers (R2)
        stim = {};
        service(4'd2, 3'd7, 0);
        service(4'd4, 3'd1, 0);
        service(4'd0, 3'd2, 0);
        // aborted, reset completed, ECC plus retries, DMA error
        stim = '{16'h0105};
        service(4'd9, 3'd4, 0);
        service(4'hA, 3'd4, 0);
        service(4'd7, 3'd2, 0);
        service(4'hD, 3'd3, 0);
        // attention error then a normal completion (R10)
        stim = {};
        service(4'hF, 3'd1, 0);
        stim = '{16'h0202, 16'h0044};
        service(4'd1, 3'd1, 0);
        // reset clears fatal (R10, R12)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!fatal && resid_cnt == '0 && sblk == '0, "R12", "state after second reset",
            fatal, 0);
        exp_fatal = 1'b0;
        exp_resid = '0;
        finish_run();
    end
endmodule